// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Front End

This block answers as a byte-addressed nonvolatile memory target on a two-wire serial bus (I2C). It follows START and STOP conditions on the bus and answers only to its own 7-bit identifier. It takes a one-byte word address and then buffers up to a page of write data. It returns read data from a single address counter. The storage is a 256-byte register array that comes out of reset erased to 0xFF. Write data is held in a page staging buffer and goes into the array only when the master ends the transfer with STOP. After that, an internal programming interval of a parameterized number of clocks begins. During that interval the block stays silent on its own address, so a master can poll for completion.

SCL and SDA are oversampled by the system clock through a synchronizer, so the bus must run well below the clock rate: each SCL level lasts a few clocks. SDA is driven only as an open-drain pull-down enable. A supervisory hold input drops any bus transfer in progress and blocks new ones while it is high. An internal programming interval that has already started still runs to its end. The block has no streaming data port, so there is no back-pressure to describe.

Top module: `i2cee_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a START the first byte is compared on its upper seven bits against the identifier 7'b1010000 (bit 0 is read=1/write=0). The block pulls SDA low on the ninth clock only when the identifier matches.
- R2: In a write transfer, the block pulls SDA low on the ninth clock after the word-address byte and after every data byte.
- R3: The first byte after a matching write identifier loads the 8-bit word address. A single data byte followed by STOP stores that byte at that address.
- R4: Each data byte in a write advances only address bits [3:0]. Bits [7:4] stay fixed. More than 16 data bytes wrap within the 16-byte page and replace the bytes sent earlier to the same slots.
- R5: Write data reaches the array only at STOP. A START that comes before the STOP discards the buffered bytes, and no programming interval follows.
- R6: A STOP that commits data starts a busy interval of WR_CYCLES clocks. During it the identifier is not acknowledged. After it ends the identifier is acknowledged again.
- R7: A read issued without a new word address returns the byte at the last accessed address plus one.
- R8: A repeated START after a write identifier and a word address, followed by a read identifier, returns data from that word address.
- R9: In a read, each master ACK (SDA low on the ninth clock) makes the block send the next byte. The address advances over all 8 bits and wraps from 0xFF to 0x00. After a master NACK, SDA stays released until the next START.
- R10: Read bytes are sent most significant bit first. The block changes its SDA drive only while SCL is low.
- R11: While hold_i is high, SDA is released and any transfer is dropped. Buffered write data is discarded, the identifier is not acknowledged, and no commit happens. A busy interval that is already running still completes.
- R12: After rst_n, SDA is released and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| hold_i | input | 1 | Supervisory hold; high means abandon and refuse transfers |
| sda_oe_o | output | 1 | Pull-down enable for SDA; 1 drives the line low |

## Verification
On every cycle, the assertions check three things. The SDA drive never moves while the sampled SCL stays high, unless hold is active. An identifier byte that arrives during a busy interval is never acknowledged. Hold forces the bus engine to idle with SDA released. They also check that a data byte never alters the page bits of the address, that at most one staging slot is written per byte, and that a commit never lands on a running busy interval. The stored values themselves can be shown only by the bench's scenarios: page wrap and overwrite, discard on repeated START, the continuation address for current reads, the full-width read wrap across 0xFF, and completion of a programming interval under hold. The bench shows these by writing the whole array with a computed pattern and reading it back through every access mode.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDATA,
    ST_RDATA,
    ST_MACK
  } bus_st_e;
endpackage

// File: rtl/i2cee_sync.sv
module i2cee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_q,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cee_array.sv
module i2cee_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [i2cee_pkg::BYTE_W-1:0] rd_data_o,
  input  logic                       we_i,
  input  logic [PAGE_W-1:0]          idx_i,
  input  logic [i2cee_pkg::BYTE_W-1:0] din_i,
  input  logic                       clr_i,
  input  logic                       commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]   commit_page_i,
  output logic                       dirty_o
);
  import i2cee_pkg::*;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [BYTE_W-1:0]     mem [DEPTH];
  logic [BYTE_W-1:0]     page_buf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [PAGE_BYTES-1:0] slot_we;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    assign slot_we[g] = we_i && (idx_i == PAGE_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) page_buf[i] <= '0;
    end else if (clr_i) begin
      mask <= '0;
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (slot_we[i]) begin
          page_buf[i] <= din_i;
          mask[i]     <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit_i) begin
      for (int j = 0; j < PAGE_BYTES; j++)
        if (mask[j]) mem[{commit_page_i, PAGE_W'(j)}] <= page_buf[j];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
  assign dirty_o   = |mask;

  // R4
  slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));
endmodule

// File: rtl/i2cee_wtimer.sv
module i2cee_wtimer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start_i)       cnt <= CW'(CYCLES);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  // R6
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave #(
  parameter logic [6:0] DEV_ID    = 7'b1010000,
  parameter int         ADDR_W    = 8,
  parameter int         PAGE_W    = 4,
  parameter int         WR_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic hold_i,
  output logic sda_oe_o
);
  import i2cee_pkg::*;
  localparam int PAGE_N = ADDR_W - PAGE_W;

  logic scl_s, scl_q, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  bus_st_e           st;
  logic [3:0]        bit_cnt;
  logic              in_ack, rw, mack, sda_oe;
  logic [BYTE_W-1:0] rx_sh, tx_sh, rd_data;
  logic [ADDR_W-1:0] ptr;
  logic              busy, dirty, commit, buf_we, buf_clr, byte_done;

  i2cee_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .scl_q(scl_q), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

  assign byte_done = scl_fall && !in_ack && (bit_cnt == 4'd8) &&
                     (st == ST_DEV || st == ST_WORD || st == ST_WDATA);
  assign buf_we  = byte_done && (st == ST_WDATA) && !hold_i;
  assign buf_clr = hold_i || start_ev || stop_ev;
  assign commit  = stop_ev && !hold_i && dirty;

  i2cee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) array_i (
    .clk(clk), .rst_n(rst_n), .rd_addr_i(ptr), .rd_data_o(rd_data),
    .we_i(buf_we), .idx_i(ptr[PAGE_W-1:0]), .din_i(rx_sh), .clr_i(buf_clr),
    .commit_i(commit), .commit_page_i(ptr[ADDR_W-1:PAGE_W]), .dirty_o(dirty));

  i2cee_wtimer #(.CYCLES(WR_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bit_cnt <= '0; in_ack <= 1'b0; rw <= 1'b0;
      mack <= 1'b0; sda_oe <= 1'b0; rx_sh <= '0; tx_sh <= '0; ptr <= '0;
    end else if (hold_i) begin
      st <= ST_IDLE; sda_oe <= 1'b0; in_ack <= 1'b0; bit_cnt <= '0;
    end else if (start_ev) begin
      st <= ST_DEV; sda_oe <= 1'b0; in_ack <= 1'b0; bit_cnt <= '0;
    end else if (stop_ev) begin
      st <= ST_IDLE; sda_oe <= 1'b0; in_ack <= 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (scl_rise && !in_ack && bit_cnt != 4'd8) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (st == ST_DEV) begin
              if (rx_sh[7:1] == DEV_ID && !busy) begin
                in_ack <= 1'b1; sda_oe <= 1'b1; rw <= rx_sh[0];
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              if (st == ST_WORD) ptr <= rx_sh;
              else ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
              in_ack <= 1'b1; sda_oe <= 1'b1;
            end
          end else if (scl_fall && in_ack) begin
            in_ack <= 1'b0; bit_cnt <= '0;
            if (st == ST_DEV && rw) begin
              st <= ST_RDATA; tx_sh <= rd_data; sda_oe <= ~rd_data[7];
            end else begin
              sda_oe <= 1'b0;
              st <= (st == ST_DEV) ? ST_WORD : ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0; st <= ST_MACK; ptr <= ptr + 1'b1; bit_cnt <= '0;
            end else begin
              tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~tx_sh[BYTE_W-2];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              st <= ST_RDATA; tx_sh <= rd_data; sda_oe <= ~rd_data[7]; bit_cnt <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe;

  // R10
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !hold_i) |=> $stable(sda_oe));
  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_DEV && busy) |=> !sda_oe);
  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (st == ST_IDLE && !sda_oe));
  // R4
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
  // R9
  mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK) |-> !sda_oe);
endmodule

// File: tb/i2cee_slave_tb.sv
module i2cee_slave_tb_top;
  localparam int WR_CYC = 300;
  localparam int Q      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic hold = 1'b0;
  logic sda_oe;
  logic sda_bus;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  assign sda_bus = msda & ~sda_oe;

  i2cee_slave #(.WR_CYCLES(WR_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .hold_i(hold), .sda_oe_o(sda_oe));

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    msda = 1'b1; q(); scl = 1'b1; q(); msda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    msda = 1'b0; q(); scl = 1'b1; q(); msda = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    msda = 1'b1; q(); scl = 1'b1; q(); ack = !sda_bus; q(); scl = 1'b0; q();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      msda = 1'b1; q(); scl = 1'b1; q(); d[i] = sda_bus; q(); scl = 1'b0; q();
    end
    msda = !give_ack; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic probe(output bit ack);
    i2c_start(); send_byte(8'hA0, ack); i2c_stop();
  endtask

  task automatic wait_ready();
    bit ack = 1'b0;
    for (int t = 0; t < 20 && !ack; t++) probe(ack);
  endtask

  task automatic write_seq(input logic [7:0] a, input int n, input int seed,
                           input string req);
    bit ack;
    int nacks = 0;
    i2c_start();
    send_byte(8'hA0, ack); if (!ack) nacks++;
    send_byte(a, ack);     if (!ack) nacks++;
    for (int i = 0; i < n; i++) begin
      logic [7:0] wa;
      wa = {a[7:4], 4'(a[3:0] + 4'(i))};
      send_byte(pat(seed + i), ack); if (!ack) nacks++;
      model[wa] = pat(seed + i);
    end
    i2c_stop();
    chk(nacks == 0, req, nacks, 0);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    i2c_start(); send_byte(8'hA0, ack); send_byte(a, ack);
    i2c_start(); send_byte(8'hA1, ack);
    chk(ack, "R8 read id ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(d == model[8'(a + i)], req, d, model[8'(a + i)]);
    end
    i2c_stop();
    chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
  endtask

  task automatic cur_read(input logic [7:0] a, input string req);
    bit ack;
    logic [7:0] d;
    i2c_start(); send_byte(8'hA1, ack); recv_byte(1'b0, d); i2c_stop();
    chk(d == model[a], req, d, model[a]);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12: SDA released after reset
    chk(sda_oe == 1'b0, "R12 reset sda", sda_oe, 0);

    // R1: every 7-bit identifier, write direction
    for (int a = 0; a < 128; a++) begin
      i2c_start(); send_byte({7'(a), 1'b0}, ack); i2c_stop();
      chk(ack == (a == 7'b1010000), "R1 id match", ack, a == 7'b1010000);
    end

    // R12: erased array, R9 wrap on read of erased top bytes
    rand_read(8'hFE, 3, "R12 erased");

    // R3 R2: byte write then R6 busy polling
    write_seq(8'h21, 1, 100, "R2 write acks");
    probe(ack);
    chk(!ack, "R6 busy nack", ack, 0);
    repeat (WR_CYC) @(negedge clk);
    probe(ack);
    chk(ack, "R6 ready ack", ack, 1);
    rand_read(8'h21, 1, "R3 byte write");
    // R7: continuation after reading 0x21
    cur_read(8'h22, "R7 current read");

    // R4: 18 bytes from offset 5 wrap inside page 0x30
    write_seq(8'h35, 18, 7, "R2 page acks");
    wait_ready();
    rand_read(8'h30, 17, "R4 page wrap");

    // R5: repeated START discards buffered data
    i2c_start(); send_byte(8'hA0, ack); send_byte(8'h50, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack);
    i2c_start(); send_byte(8'hA0, ack);
    chk(ack, "R5 no busy after discard", ack, 1);
    send_byte(8'h50, ack);
    i2c_start(); send_byte(8'hA1, ack);
    recv_byte(1'b1, d); chk(d == model[8'h50], "R5 discard", d, model[8'h50]);
    recv_byte(1'b0, d); chk(d == model[8'h51], "R5 discard", d, model[8'h51]);
    i2c_stop();

    // R11: hold drops a write in progress
    i2c_start(); send_byte(8'hA0, ack); send_byte(8'h60, ack); send_byte(8'hAB, ack);
    hold = 1'b1; repeat (10) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 hold release", sda_oe, 0);
    i2c_stop();
    probe(ack);
    chk(!ack, "R11 id refused in hold", ack, 0);
    hold = 1'b0; repeat (4) @(negedge clk);
    probe(ack);
    chk(ack, "R11 no commit under hold", ack, 1);
    rand_read(8'h60, 1, "R11 data dropped");

    // R11: running busy interval completes under hold
    write_seq(8'h70, 1, 55, "R2 write acks");
    hold = 1'b1; repeat (WR_CYC + 20) @(negedge clk); hold = 1'b0;
    repeat (4) @(negedge clk);
    probe(ack);
    chk(ack, "R11 cycle finished", ack, 1);
    rand_read(8'h70, 1, "R11 cycle committed");

    // R4 R9 R10: fill whole array, then read across the 0xFF wrap
    for (int p = 0; p < 16; p++) begin
      write_seq(8'(p * 16), 16, p * 16, "R2 fill acks");
      wait_ready();
    end
    rand_read(8'hF8, 264, "R9 R10 sequential");
    cur_read(8'h00, "R7 after wrap");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule